// File: doc/BRIEF.md
# Cache-Line Burst Address Generator

This block holds the array address for a four-beat cache-line burst. When the surrounding control logic accepts an address strobe, the block captures a full external address. It then produces the remaining beats of the line by stepping only the two lowest address bits. The upper bits stay fixed for the whole line.

Two step orders are available. Linear order counts up and wraps modulo four. Interleaved order XORs the start pair with the beat number. A static order-select input picks between them. That input is not registered, so the mapping it chooses takes effect at once.

Internally the block keeps the captured start pair and a separate 2-bit beat counter. The output low pair is formed from those two values and the order select.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and after its release, with no load yet, `addr_o` is all zeros.
- R2: When `load_i` is high at a rising clock edge, `addr_o` equals the `addr_i` sampled at that edge from just after the edge.
- R3: With `order_i` = 0 (linear), the low pair after n advances from start pair s is (s + n) mod 4.
- R4: With `order_i` = 1 (interleaved), the low pair after n advances from start pair s is s XOR n. For example, a start of 01 gives 01, 00, 11, 10.
- R5: Bits `addr_o[ADDR_W-1:2]` never change except on a load.
- R6: If `adv_ni` is high and `load_i` is low at an edge, `addr_o` keeps its value, provided `order_i` does not change.
- R7: After four advances the low pair returns to the start pair, in either order.
- R8: A load in the middle of a burst discards the burst in progress. Stepping restarts from the new address with a beat count of zero.
- R9: If `load_i` is high and `adv_ni` is low at the same edge, the output is the loaded address with a beat count of zero. The next advance yields beat one.
- R10: `order_i` is not registered. A change of `order_i` between edges changes `addr_o` at once, remapping the current beat count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Accepted address strobe; captures `addr_i` |
| adv_ni | input | 1 | Advance, active low; steps the beat counter |
| order_i | input | 1 | Static order select: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | External address |
| addr_o | output | ADDR_W | Current array address |

## Verification
Several properties are checked on every clock cycle:
- the load capture;
- the stability of the upper bits between loads;
- holding while advance is inactive;
- the +1 step in linear order;
- the flip of bit 0 on every interleaved step.

Some behaviours only the bench scenarios can show:
- the full interleaved sequence values;
- wrap-around after four beats;
- the restart of the beat count on a load mid-burst or a load together with an advance;
- the immediate remapping when the order select changes between edges.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int LOW_W = 2;
  typedef logic [LOW_W-1:0] low_t;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} order_e;
endpackage

// File: rtl/burst_step_ctr.sv
module burst_step_ctr
  import burst_addr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output low_t cnt_o
);
  low_t cnt_q;

  // clear wins over step: a load restarts the beat count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + low_t'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
  import burst_addr_pkg::*;
(
  input  low_t   start_i,
  input  low_t   cnt_i,
  input  order_e order_i,
  output low_t   low_o
);
  always_comb begin
    unique case (order_i)
      ORD_XOR: low_o = start_i ^ cnt_i;
      default: low_o = start_i + cnt_i;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_ni,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - LOW_W;

  logic [HI_W-1:0] hi_q;
  low_t            start_q;
  low_t            cnt;
  low_t            low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      start_q <= '0;
    end else if (load_i) begin
      hi_q    <= addr_i[ADDR_W-1:LOW_W];
      start_q <= addr_i[LOW_W-1:0];
    end
  end

  burst_step_ctr u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_i),
    .step_i (~adv_ni),
    .cnt_o  (cnt)
  );

  // order_i feeds the mapping directly (not registered)
  burst_low_map u_map (
    .start_i (start_q),
    .cnt_i   (cnt),
    .order_i (order_e'(order_i)),
    .low_o   (low)
  );

  assign addr_o = {hi_q, low};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              adv_ni,
  input logic              order_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o
);
  // R2
  load_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(addr_i));

  // R5
  upper_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni) |=> (order_i != $past(order_i)) || $stable(addr_o));

  // R3
  linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni && !order_i) |=>
      order_i || (addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1)));

  // R4
  xor_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni && order_i) |=>
      !order_i || (addr_o[0] != $past(addr_o[0])));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;
  localparam int ADDR_W = 17;
  localparam int NV = 15;

  typedef struct packed {
    logic [3:0]        req;
    logic              ld;
    logic              adv_n;
    logic              ord;
    logic [ADDR_W-1:0] a;
    logic [ADDR_W-1:0] e;
  } vec_t;

  // R2 load, R3 linear, R5 upper kept, R7 wrap, R6 hold, R4 interleaved,
  // R9 load with advance, R8 load mid-burst
  localparam vec_t VEC [NV] = '{
    '{4'd2, 1'b1, 1'b1, 1'b0, 17'h1ABC5, 17'h1ABC5},
    '{4'd3, 1'b0, 1'b0, 1'b0, 17'h00000, 17'h1ABC6},
    '{4'd3, 1'b0, 1'b0, 1'b0, 17'h00000, 17'h1ABC7},
    '{4'd5, 1'b0, 1'b0, 1'b0, 17'h00000, 17'h1ABC4},
    '{4'd7, 1'b0, 1'b0, 1'b0, 17'h00000, 17'h1ABC5},
    '{4'd6, 1'b0, 1'b1, 1'b0, 17'h00000, 17'h1ABC5},
    '{4'd2, 1'b1, 1'b1, 1'b1, 17'h0F0F1, 17'h0F0F1},
    '{4'd4, 1'b0, 1'b0, 1'b1, 17'h00000, 17'h0F0F0},
    '{4'd4, 1'b0, 1'b0, 1'b1, 17'h00000, 17'h0F0F3},
    '{4'd4, 1'b0, 1'b0, 1'b1, 17'h00000, 17'h0F0F2},
    '{4'd7, 1'b0, 1'b0, 1'b1, 17'h00000, 17'h0F0F1},
    '{4'd9, 1'b1, 1'b0, 1'b0, 17'h0003E, 17'h0003E},
    '{4'd9, 1'b0, 1'b0, 1'b0, 17'h00000, 17'h0003F},
    '{4'd8, 1'b1, 1'b1, 1'b0, 17'h12346, 17'h12346},
    '{4'd8, 1'b0, 1'b0, 1'b0, 17'h00000, 17'h12347}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load = 1'b0;
  logic              adv_n = 1'b1;
  logic              order = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [ADDR_W-1:0] addr_out;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_burst_addr_gen (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .load_i  (load),
    .adv_ni  (adv_n),
    .order_i (order),
    .addr_i  (addr),
    .addr_o  (addr_out)
  );

  task automatic check(input int req, input logic [ADDR_W-1:0] exp);
    total++;
    if (addr_out !== exp) begin
      bad++;
      $display("FAIL R%0d: addr_o=%h expected=%h", req, addr_out, exp);
    end
  endtask

  task automatic step(input logic l, input logic an, input logic o,
                      input logic [ADDR_W-1:0] a);
    @(negedge clk);
    load = l; adv_n = an; order = o; addr = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, '0);  // R1 during reset
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(1, '0);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].ld, VEC[i].adv_n, VEC[i].ord, VEC[i].a);
      check(int'(VEC[i].req), VEC[i].e);
    end

    // R10: order change between edges remaps immediately
    step(1'b1, 1'b1, 1'b0, 17'h00005);
    step(1'b0, 1'b0, 1'b0, 17'h00000);
    check(10, 17'h00006);
    @(negedge clk); adv_n = 1'b1; order = 1'b1; #1;
    check(10, 17'h00004);  // R10: 01 ^ 01
    order = 1'b0; #1;
    check(10, 17'h00006);  // R10: back to linear

    // R1: reset mid-burst clears the output
    @(negedge clk); rst_n = 1'b0; #1;
    check(1, '0);
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule